// File: doc/BRIEF.md
# Serialized Interrupt Slave with Clock-Restart Request

This block is the peripheral end of a single-wire serialized interrupt bus. It watches the shared open-drain line, follows each interrupt cycle from its start frame, through the numbered IRQ slots, to the stop frame, and reports one local interrupt source in a configurable slot. Each cycle runs in one of two modes, continuous or quiet. The mode for a cycle is taken from the width of the stop frame of the cycle before it. In continuous mode only the host opens cycles. In quiet mode the peripheral may open a cycle itself when it has an interrupt that it has not yet reported.

Quiet mode lets the host halt the bus clock. For that case the block has a clock-restart requester on the shared CLKRUN line, which has a pull-up. When the line reads high, the clock is stopped or is being stopped. If a report is needed, the requester pulls the line low and holds it until the restarted clock has delivered two edges. It then leaves the line to the host, which holds it low while the clock runs.

All frame logic runs on the system clock `clk`, and advances only on cycles where `lclk_en` marks a bus-clock edge. A stopped bus clock appears as `lclk_en` held low. The requester runs on every `clk` cycle, so it can act while the bus clock is stopped. Both shared lines are presented as an output enable plus a drive value, and the line value is read back on a separate input.

Top module: `serirq_slave`

## Requirements
- R1: After reset the mode is continuous (`quiet_mode`=0), `serirq_oe`=0 and `clkrun_oe`=0.
- R2: A stop frame of exactly two low bus-clock periods selects quiet mode (`quiet_mode`=1) for the next cycle. A stop frame of three or more low periods selects continuous mode. The mode updates at the edge that samples the line high again after the stop frame.
- R3: In continuous mode the block never starts a cycle and never drives CLKRUN, even with an interrupt pending and the clock stopped.
- R4: Let P be the bus-clock period in which the line first reads high after the start frame's low periods. Slot s then takes the three periods that follow P at offsets 3s+1, 3s+2 and 3s+3: sample, recovery and turnaround. If `irq_req` was high during the start frame, the block drives low (`serirq_oe`=1, `serirq_o`=0) in the sample period of slot `slot_sel`, drives high in recovery, and releases in turnaround.
- R5: With `irq_req` low during the start frame, the block drives no slot.
- R6: In quiet mode and while idle, an interrupt that has not been reported makes the block drive the line low for exactly one bus-clock period. That period counts as the first period of the start frame. The block then releases the line.
- R7: Once an interrupt has been reported in a slot, the block starts no further cycle until `irq_req` has gone low and then high again.
- R8: In quiet mode, with an interrupt not yet reported, the block pulls CLKRUN low (`clkrun_oe`=1) only after sampling `clkrun_i` high. It releases the line at the second bus-clock edge after that.
- R9: While CLKRUN reads low, the block does not drive it, even when it starts its own cycle.
- R10: Slot selection covers both ends of the range: slot 0 and slot `NUM_SLOTS`-1 (15 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| lclk_en | input | 1 | High on `clk` cycles that are bus-clock edges |
| irq_req | input | 1 | Local interrupt level |
| slot_sel | input | SLOT_W | Slot the interrupt is reported in |
| serirq_i | input | 1 | Sampled value of the serialized interrupt line |
| serirq_oe | output | 1 | Drive enable for the serialized interrupt line |
| serirq_o | output | 1 | Value driven when enabled |
| clkrun_i | input | 1 | Sampled value of the clock-run line |
| clkrun_oe | output | 1 | Pulls the clock-run line low when high |
| quiet_mode | output | 1 | Mode of the next cycle, 1 = quiet |

## Verification
The bench targets the first and last slot positions. If the start turnaround is counted wrongly, the drive shifts by one period, and the per-clock comparison sees it. Each stop width is run in turn. If the low-count decode is wrong, the block kicks in continuous mode, or fails to kick in quiet mode. The clock-restart sequence runs with the bus clock held off. It checks that the request starts only when the line reads high, that it spans exactly two restarted edges, and that it never appears in continuous mode. After a report, the bench also checks that a still-asserted source does not start cycles over and over.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  typedef enum logic [2:0] {
    FR_IDLE, FR_KICK, FR_START, FR_SLOT, FR_STOP
  } frame_st_e;

  typedef enum logic [1:0] {
    PH_SAMPLE, PH_RECOVER, PH_TURN
  } slot_ph_e;
endpackage

// File: rtl/serirq_frame_trk.sv
module serirq_frame_trk
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int STOP_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_i,
  input  logic              kick_req,
  output frame_st_e         st,
  output logic [SLOT_W-1:0] slot_idx,
  output slot_ph_e          phase,
  output logic              quiet
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [STOP_W-1:0] QUIET_W   = STOP_W'(2);

  logic [STOP_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FR_IDLE;
      slot_idx <= '0;
      phase    <= PH_SAMPLE;
      low_cnt  <= '0;
      quiet    <= 1'b0;
    end else if (tick) begin
      case (st)
        FR_IDLE: begin
          if (!line_i)                st <= FR_START;
          else if (kick_req && quiet) st <= FR_KICK;
        end
        FR_KICK:  st <= FR_START;
        FR_START: begin
          if (line_i) begin
            st       <= FR_SLOT;
            slot_idx <= '0;
            phase    <= PH_SAMPLE;
          end
        end
        FR_SLOT: begin
          case (phase)
            PH_SAMPLE:  phase <= PH_RECOVER;
            PH_RECOVER: phase <= PH_TURN;
            default: begin
              phase <= PH_SAMPLE;
              if (slot_idx == LAST_SLOT) begin
                st      <= FR_STOP;
                low_cnt <= '0;
              end else begin
                slot_idx <= slot_idx + 1'b1;
              end
            end
          endcase
        end
        FR_STOP: begin
          if (!line_i) begin
            if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
          end else begin
            if (low_cnt == QUIET_W)     quiet <= 1'b1;
            else if (low_cnt > QUIET_W) quiet <= 1'b0;
            st <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serirq_slot_drv.sv
module serirq_slot_drv
  import serirq_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_st_e         st,
  input  logic [SLOT_W-1:0] slot_idx,
  input  slot_ph_e          phase,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              irq_req,
  output logic              drv_oe,
  output logic              drv_o,
  output logic              unreported
);
  logic hit;
  logic sent;
  logic mine;

  assign mine       = (st == FR_SLOT) && (slot_idx == slot_sel) && hit;
  assign unreported = irq_req && !sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit  <= 1'b0;
      sent <= 1'b0;
    end else begin
      if (tick && st == FR_START) hit <= irq_req;
      if (!irq_req)                                    sent <= 1'b0;
      else if (tick && mine && phase == PH_SAMPLE)     sent <= 1'b1;
    end
  end

  always_comb begin
    drv_oe = 1'b0;
    drv_o  = 1'b1;
    if (st == FR_KICK) begin
      drv_oe = 1'b1;
      drv_o  = 1'b0;
    end else if (mine && phase == PH_SAMPLE) begin
      drv_oe = 1'b1;
      drv_o  = 1'b0;
    end else if (mine && phase == PH_RECOVER) begin
      drv_oe = 1'b1;
      drv_o  = 1'b1;
    end
  end
endmodule

// File: rtl/serirq_clkrun_req.sv
module serirq_clkrun_req #(
  parameter int RESTART_EDGES = 2,
  parameter int CNT_W         = $clog2(RESTART_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic need,
  input  logic clkrun_i,
  output logic pull_low
);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(RESTART_EDGES - 1);

  logic [CNT_W-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_low <= 1'b0;
      edge_cnt <= '0;
    end else if (!pull_low) begin
      if (need && clkrun_i) begin
        pull_low <= 1'b1;
        edge_cnt <= '0;
      end
    end else if (!need) begin
      pull_low <= 1'b0;
    end else if (tick) begin
      if (edge_cnt == LAST_EDGE) pull_low <= 1'b0;
      else                       edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serirq_slave.sv
module serirq_slave
  import serirq_pkg::*;
#(
  parameter  int NUM_SLOTS     = 16,
  parameter  int RESTART_EDGES = 2,
  localparam int SLOT_W        = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lclk_en,
  input  logic              irq_req,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              serirq_i,
  output logic              serirq_oe,
  output logic              serirq_o,
  input  logic              clkrun_i,
  output logic              clkrun_oe,
  output logic              quiet_mode
);
  frame_st_e         fr_st;
  slot_ph_e          fr_phase;
  logic [SLOT_W-1:0] fr_slot;
  logic              unreported;
  logic              fr_kick;
  logic              fr_in_slots;

  assign fr_kick     = (fr_st == FR_KICK);
  assign fr_in_slots = (fr_st == FR_SLOT);

  serirq_frame_trk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (lclk_en),
    .line_i   (serirq_i),
    .kick_req (unreported),
    .st       (fr_st),
    .slot_idx (fr_slot),
    .phase    (fr_phase),
    .quiet    (quiet_mode)
  );

  serirq_slot_drv #(.SLOT_W(SLOT_W)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (lclk_en),
    .st         (fr_st),
    .slot_idx   (fr_slot),
    .phase      (fr_phase),
    .slot_sel   (slot_sel),
    .irq_req    (irq_req),
    .drv_oe     (serirq_oe),
    .drv_o      (serirq_o),
    .unreported (unreported)
  );

  serirq_clkrun_req #(.RESTART_EDGES(RESTART_EDGES)) u_ckr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (lclk_en),
    .need     (quiet_mode && unreported),
    .clkrun_i (clkrun_i),
    .pull_low (clkrun_oe)
  );
endmodule

// File: rtl/serirq_slave_chk.sv
module serirq_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic lclk_en,
  input logic serirq_oe,
  input logic serirq_o,
  input logic clkrun_i,
  input logic clkrun_oe,
  input logic quiet_mode,
  input logic kick,
  input logic in_slots
);
  // R6: a self-started low lasts one bus-clock period
  a_r6_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (lclk_en && kick) |=> !(serirq_oe && !serirq_o));

  // R3: self-start only in quiet mode
  a_r3_kick_quiet_only: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> quiet_mode);

  // R4: sample low is followed by a recovery high
  a_r4_recover_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lclk_en && in_slots && serirq_oe && !serirq_o) |=> (serirq_oe && serirq_o));

  // R4: recovery high is followed by release
  a_r4_turn_release: assert property (@(posedge clk) disable iff (!rst_n)
    (lclk_en && in_slots && serirq_oe && serirq_o) |=> !serirq_oe);

  // R8: request starts only after the line read high
  a_r8_req_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkrun_oe) |-> $past(clkrun_i));

  // R3: restart request never raised in continuous mode
  a_r3_req_quiet_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkrun_oe) |-> $past(quiet_mode));
endmodule

bind serirq_slave serirq_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lclk_en    (lclk_en),
  .serirq_oe  (serirq_oe),
  .serirq_o   (serirq_o),
  .clkrun_i   (clkrun_i),
  .clkrun_oe  (clkrun_oe),
  .quiet_mode (quiet_mode),
  .kick       (fr_kick),
  .in_slots   (fr_in_slots)
);

// File: tb/serirq_slave_tb.sv
module serirq_slave_tb;
  localparam int NSLOT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lclk_en = 1'b1;
  logic       irq_req = 1'b0;
  logic [3:0] slot_sel = 4'd5;
  logic       host_sq_oe = 1'b0;
  logic       host_sq_o = 1'b1;
  logic       host_ck_oe = 1'b1;
  logic       sq_oe, sq_o, ck_oe, quiet;
  logic       sq_line, ck_line;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign sq_line = sq_oe ? sq_o : (host_sq_oe ? host_sq_o : 1'b1);
  assign ck_line = !(ck_oe || host_ck_oe);

  serirq_slave u_dut (
    .clk(clk), .rst_n(rst_n), .lclk_en(lclk_en), .irq_req(irq_req),
    .slot_sel(slot_sel), .serirq_i(sq_line), .serirq_oe(sq_oe),
    .serirq_o(sq_o), .clkrun_i(ck_line), .clkrun_oe(ck_oe),
    .quiet_mode(quiet)
  );

  // one bus-clock period: compare outputs, then set host drive for it
  task automatic tick(input logic h_oe, input logic h_o, input logic e_oe,
                      input logic e_o, input logic e_ck, input string tag);
    @(negedge clk);
    n_tests++;
    if (sq_oe !== e_oe || (e_oe && sq_o !== e_o) || ck_oe !== e_ck) begin
      n_fail++;
      $display("FAIL %s: oe/o/ck actual %b%b%b expected %b%b%b",
               tag, sq_oe, sq_o, ck_oe, e_oe, e_o, e_ck);
    end
    host_sq_oe = h_oe;
    host_sq_o  = h_o;
  endtask

  task automatic idle(input int n, input logic e_ck, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, 1'b1, e_ck, tag);
  endtask

  task automatic check_mode(input logic exp, input string tag);
    n_tests++;
    if (quiet !== exp) begin
      n_fail++;
      $display("FAIL %s: quiet_mode actual %b expected %b", tag, quiet, exp);
    end
  endtask

  task automatic run_cycle(input int start_len, input int stop_len,
                           input bit kick, input int ck_n, input bit hit,
                           input string tag);
    int k = 0;
    for (int i = 0; i < start_len; i++) begin
      if (i == 0 && kick) tick(1'b0, 1'b1, 1'b1, 1'b0, (k < ck_n), tag);
      else                tick(1'b1, 1'b0, 1'b0, 1'b1, (k < ck_n), tag);
      k++;
    end
    tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, tag);
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < 3; p++)
        tick(1'b0, 1'b1, hit && (s == int'(slot_sel)) && (p < 2), (p == 1),
             1'b0, tag);
    for (int i = 0; i < stop_len; i++) tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, tag);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, tag);
    tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b0, "R1 reset state");
    check_mode(1'b0, "R1 reset mode");

    run_cycle(4, 3, 0, 0, 0, "R5 no irq");
    check_mode(1'b0, "R2 continuous stays");

    irq_req = 1'b1;
    run_cycle(6, 3, 0, 0, 1, "R4 slot 5");
    slot_sel = 4'd0;
    run_cycle(5, 4, 0, 0, 1, "R10 slot 0");
    slot_sel = 4'd15;
    run_cycle(8, 3, 0, 0, 1, "R10 slot 15");
    check_mode(1'b0, "R2 wide stop continuous");

    // continuous, unreported irq, clock stopped: no kick, no clkrun
    irq_req = 1'b0;
    idle(3, 1'b0, "R3 irq low");
    irq_req = 1'b1;
    idle(10, 1'b0, "R3 no kick continuous");
    host_ck_oe = 1'b0;
    idle(2, 1'b0, "R3 clkrun released");
    lclk_en = 1'b0;
    idle(20, 1'b0, "R3 no clkrun continuous");
    lclk_en = 1'b1;
    host_ck_oe = 1'b1;
    idle(2, 1'b0, "R3 clock resumed");

    // into quiet mode; slot 15 reports the pending irq
    run_cycle(4, 2, 0, 0, 1, "R2 to quiet");
    check_mode(1'b1, "R2 two-wide stop quiet");
    idle(12, 1'b0, "R7 no repeat kick");

    irq_req = 1'b0;
    idle(3, 1'b0, "R7 irq dropped");
    irq_req = 1'b1;
    run_cycle(4, 2, 1, 0, 1, "R6 R9 self start");
    check_mode(1'b1, "R2 quiet kept");
    idle(12, 1'b0, "R7 no kick after report");

    // clock stop in quiet mode and restart request
    irq_req = 1'b0;
    idle(3, 1'b0, "R8 irq low");
    host_ck_oe = 1'b0;
    idle(2, 1'b0, "R8 host releases");
    lclk_en = 1'b0;
    idle(4, 1'b0, "R8 no request without irq");
    irq_req = 1'b1;
    idle(3, 1'b1, "R8 request while stopped");
    lclk_en = 1'b1;
    host_ck_oe = 1'b1;
    run_cycle(5, 3, 1, 1, 1, "R8 restart two edges");
    check_mode(1'b0, "R2 back to continuous");
    idle(10, 1'b0, "R3 after return");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule